// File: doc/BRIEF.md
# Time-Multiplexed Overflow Flag Generator

This block watches overrange pulses from the left and right conversion channels and drives a single active-low status line. The line carries both channel flags, time-multiplexed by the frame clock. A receiver recovers the per-channel status by latching the line on the edges of the frame clock. Any overrange on either channel pulls both channel flags low at once and restarts one shared hold-off timer. The flags go high again only when that timer runs out with no further overrange.

The hold-off is counted in output samples, and its length depends on the speed mode. The base length is 2^HOLD_LOG2 samples at single speed. It doubles at double speed and quadruples at quad speed, so the hold lasts roughly the same wall-clock time in every mode. With the default HOLD_LOG2 = 15, this comes to a few hundred milliseconds.

The block runs on one system clock. The serial bit clock enters as a strobe marking each bit-clock falling edge, and the frame clock enters as a level. The line changes only on a bit-clock falling edge at a fixed bit offset after each frame-clock transition. That offset depends on the serial format. This keeps the line stable for most of each half-frame, so it is always settled well before the next frame-clock edge that latches it.

Top module: `ovf_mux_flag`

## Requirements
- R1: After reset the flag line `ovfl_n` is high and no hold is active.
- R2: An overrange pulse on `ovr_left`, on `ovr_right` or on both starts a hold. The next update point then drives `ovfl_n` low.
- R3: A hold ends after exactly LIMIT rising-clock cycles with `sample_tick` high, counted after the last overrange pulse. Before that the update points keep `ovfl_n` low, and the first update point afterwards drives it high.
- R4: An overrange on either channel during a hold restarts the count from zero for the shared hold. If `sample_tick` and an overrange arrive in the same cycle, the tick is not counted.
- R5: LIMIT depends on `speed_mode`:
  - 2'b00 gives 2^HOLD_LOG2.
  - 2'b01 gives 2^(HOLD_LOG2+1).
  - 2'b10 and the reserved 2'b11 give 2^(HOLD_LOG2+2).
- R6: With `fmt_i2s` = 0 (left-justified), an update point is a `sclk_fall` cycle exactly one bit-clock falling edge after the falling edge at which `lrck` changed.
- R7: With `fmt_i2s` = 1, an update point is a `sclk_fall` cycle exactly two bit-clock falling edges after the falling edge at which `lrck` changed.
- R8: `ovfl_n` changes only on the clock edge that follows an update point. Other `sclk_fall` cycles in the half-frame, and cycles without `sclk_fall`, leave it unchanged.
- R9: `sample_tick` with no overrange keeps `ovfl_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ovr_left | input | 1 | Overrange pulse from the left channel |
| ovr_right | input | 1 | Overrange pulse from the right channel |
| sample_tick | input | 1 | One-cycle strobe per output sample |
| speed_mode | input | 2 | 00 single, 01 double, 10/11 quad speed |
| sclk_fall | input | 1 | Strobe marking a bit-clock falling edge |
| lrck | input | 1 | Frame clock level, sampled on `sclk_fall` |
| fmt_i2s | input | 1 | 0 left-justified, 1 I2S bit offset |
| ovfl_n | output | 1 | Multiplexed active-low overflow flag |

## Verification
The hold is tried with overrange on the left only, the right only and both channels. Each case is probed one tick short of LIMIT and then at LIMIT, which separates an exact hold count from an off-by-one. Every speed code is run, including the reserved one, which tells the three hold lengths apart. A second overrange in mid-hold, and an overrange coinciding with a tick, separate a true restart from a hold that only extends or that counts the coinciding tick. Frame patterns are checked fall by fall in both formats. This separates the one-edge and two-edge offsets from each other, and from a line that follows the overrange immediately or on a wrong mid-frame edge.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } speed_e;

    // bit-clock falls between a frame-clock change and the flag update
    localparam logic [1:0] OFS_LJ  = 2'd1;
    localparam logic [1:0] OFS_I2S = 2'd2;
    localparam logic [1:0] SINCE_IDLE = 2'd3;

    typedef struct packed {
        logic       lr;
        logic [1:0] since;
    } frame_st_t;

endpackage

// File: rtl/ovf_hold_timer.sv
module ovf_hold_timer
    import ovf_pkg::*;
#(
    parameter int unsigned HOLD_LOG2 = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ovr_any,
    input  logic       sample_tick,
    input  logic [1:0] speed_mode,
    output logic       hold_o
);
    localparam int unsigned CW = HOLD_LOG2 + 3;

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } hold_st_t;

    hold_st_t      s_d, s_q;
    logic [CW-1:0] last_cnt;
    speed_e        spd;

    always_comb begin
        spd = speed_e'(speed_mode);
        case (spd)
            SPD_SINGLE: last_cnt = (CW'(1) << HOLD_LOG2) - CW'(1);
            SPD_DOUBLE: last_cnt = (CW'(1) << (HOLD_LOG2 + 1)) - CW'(1);
            default:    last_cnt = (CW'(1) << (HOLD_LOG2 + 2)) - CW'(1);
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (ovr_any) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
        end else if (s_q.active && sample_tick) begin
            if (s_q.cnt == last_cnt) begin
                s_d.active = 1'b0;
                s_d.cnt    = '0;
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign hold_o = s_q.active;

    // R2
    ovr_sets_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_any |=> (hold_o && s_q.cnt == '0));

    // R3
    hold_ends_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_o && !ovr_any && !sample_tick) |=> hold_o);

    // R4
    restart_clears_count_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_o && ovr_any) |=> (s_q.cnt == '0));

endmodule

// File: rtl/ovf_frame_track.sv
module ovf_frame_track
    import ovf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk_fall,
    input  logic lrck,
    input  logic fmt_i2s,
    output logic upd_o
);
    frame_st_t  s_d, s_q;
    logic [1:0] target;

    always_comb begin
        target = fmt_i2s ? OFS_I2S : OFS_LJ;
        s_d    = s_q;
        upd_o  = 1'b0;
        if (sclk_fall) begin
            if (lrck != s_q.lr) begin
                s_d.lr    = lrck;
                s_d.since = 2'd0;
            end else if (s_q.since != SINCE_IDLE) begin
                s_d.since = s_q.since + 2'd1;
                upd_o     = (s_q.since + 2'd1) == target;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.lr    <= 1'b0;
            s_q.since <= SINCE_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // R8
    upd_needs_fall_chk: assert property (@(posedge clk) disable iff (rst)
        upd_o |-> (sclk_fall && $stable(lrck)));

    // R6
    lj_no_upd_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk_fall && lrck != s_q.lr) |-> !upd_o);

endmodule

// File: rtl/ovf_mux_flag.sv
module ovf_mux_flag
    import ovf_pkg::*;
#(
    parameter int unsigned HOLD_LOG2 = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ovr_left,
    input  logic       ovr_right,
    input  logic       sample_tick,
    input  logic [1:0] speed_mode,
    input  logic       sclk_fall,
    input  logic       lrck,
    input  logic       fmt_i2s,
    output logic       ovfl_n
);
    logic hold;
    logic upd;
    logic flag_d, flag_q;

    ovf_hold_timer #(.HOLD_LOG2(HOLD_LOG2)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .ovr_any     (ovr_left | ovr_right),
        .sample_tick (sample_tick),
        .speed_mode  (speed_mode),
        .hold_o      (hold)
    );

    ovf_frame_track u_track (
        .clk       (clk),
        .rst       (rst),
        .sclk_fall (sclk_fall),
        .lrck      (lrck),
        .fmt_i2s   (fmt_i2s),
        .upd_o     (upd)
    );

    always_comb begin
        flag_d = flag_q;
        if (upd) flag_d = ~hold;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b1;
        else     flag_q <= flag_d;
    end

    assign ovfl_n = flag_q;

    // R8
    flag_still_off_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !sclk_fall |=> $stable(ovfl_n));

    // R2
    flag_low_when_held_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && hold) |=> !ovfl_n);

endmodule

// File: tb/tb_ovf_mux_flag.sv
module tb_ovf_mux_flag;
    localparam int CLK_PERIOD = 10;
    localparam int BASE = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ovr_left = 1'b0, ovr_right = 1'b0, sample_tick = 1'b0;
    logic [1:0] speed_mode = 2'b00;
    logic       sclk_fall = 1'b0, lrck = 1'b0, fmt_i2s = 1'b0;
    logic       ovfl_n;

    int total = 0;
    int bad = 0;

    ovf_mux_flag #(.HOLD_LOG2(BASE)) dut (
        .clk(clk), .rst(rst), .ovr_left(ovr_left), .ovr_right(ovr_right),
        .sample_tick(sample_tick), .speed_mode(speed_mode),
        .sclk_fall(sclk_fall), .lrck(lrck), .fmt_i2s(fmt_i2s), .ovfl_n(ovfl_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: ovfl_n=%0b expected %0b", tag, got, exp);
        end
    endtask

    // one clock cycle: drive at negedge, result visible at the next negedge
    task automatic cyc(input logic sf, input logic tk, input logic ol, input logic orr);
        sclk_fall = sf; sample_tick = tk; ovr_left = ol; ovr_right = orr;
        @(negedge clk);
        sclk_fall = 1'b0; sample_tick = 1'b0; ovr_left = 1'b0; ovr_right = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    // frame-clock change plus enough falls to pass either update offset
    task automatic frame_sync();
        lrck = ~lrck;
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset(input logic [1:0] spd, input logic i2s);
        speed_mode = spd; fmt_i2s = i2s; lrck = 1'b0;
        rst = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset(2'b00, 1'b0);
        chk(ovfl_n, 1'b1, "R1 reset value");
        ticks(20);
        frame_sync();
        chk(ovfl_n, 1'b1, "R9 ticks alone keep flag high");
    endtask

    task automatic t_hold(input logic ol, input logic orr, input logic [1:0] spd, input int limit);
        do_reset(spd, 1'b0);
        cyc(1'b0, 1'b0, ol, orr);
        frame_sync();
        chk(ovfl_n, 1'b0, "R2 overrange drives flag low");
        ticks(limit - 1);
        frame_sync();
        chk(ovfl_n, 1'b0, "R3 R5 still held one tick short");
        ticks(1);
        frame_sync();
        chk(ovfl_n, 1'b1, "R3 R5 released at limit");
    endtask

    task automatic t_restart();
        do_reset(2'b00, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        ticks(5);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        ticks(7);
        frame_sync();
        chk(ovfl_n, 1'b0, "R4 restart by other channel");
        ticks(1);
        frame_sync();
        chk(ovfl_n, 1'b1, "R4 release after restarted count");
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        ticks(7);
        frame_sync();
        chk(ovfl_n, 1'b0, "R4 coinciding tick not counted");
        ticks(1);
        frame_sync();
        chk(ovfl_n, 1'b1, "R4 release after coinciding tick");
    endtask

    task automatic t_format(input logic i2s);
        string tag;
        tag = i2s ? "R7" : "R6";
        do_reset(2'b00, i2s);
        cyc(1'b0, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk(ovfl_n, 1'b1, {tag, " R8 no update mid-frame"});
        lrck = ~lrck;
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk(ovfl_n, 1'b1, {tag, " no update on frame edge"});
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk(ovfl_n, 1'b1, {tag, " R8 no update without fall"});
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk(ovfl_n, i2s, {tag, " first fall after edge"});
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk(ovfl_n, 1'b0, {tag, " second fall after edge"});
        ticks(8);
        lrck = ~lrck;
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk(ovfl_n, ~i2s, {tag, " release at first fall"});
        cyc(1'b1, 1'b0, 1'b0, 1'b0);
        chk(ovfl_n, 1'b1, {tag, " release at second fall"});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_hold(1'b1, 1'b0, 2'b00, 1 << BASE);
        t_hold(1'b0, 1'b1, 2'b01, 1 << (BASE + 1));
        t_hold(1'b1, 1'b1, 2'b10, 1 << (BASE + 2));
        t_hold(1'b1, 1'b0, 2'b11, 1 << (BASE + 2));
        t_restart();
        t_format(1'b0);
        t_format(1'b1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule